// File: doc/BRIEF.md
# CAN Error-State Change Interrupt

This block follows the receive and transmit error counters of a CAN controller and turns each one into a 2-bit fault-confinement state. The counters come from the protocol engine as inputs. Whenever a state moves, the block compares the move with a per-direction reporting level that software has programmed. If the level covers the move, the block sets a sticky status-change flag. Software clears the flag by writing 1 to it. The interrupt output is raised while the flag is set and its enable bit is on.

Software sees two byte-wide registers through a simple select/write port, with combinational read data:

- **Status register (select 0):** the change flag and both current states. The state fields are read-only.
- **Control register (select 1):** the interrupt enable and the two reporting levels.

While the controller is in its initialisation mode, both states are forced to OK and no change is reported. When initialisation mode ends, the states are evaluated again from the counters.

Top module: `can_err_state_irq`

## Requirements
- R1: Each direction's state follows its counter one clock after the counter is presented: 0 to 95 gives 0 (OK), 96 to 127 gives 1 (warning), 128 to 255 gives 2 (error passive), and 256 or more gives 3 (bus-off).
- R2: The status register (select 0) reads bit 6 = change flag, bits 5:4 = receive state, bits 3:2 = transmit state, and all other bits 0.
- R3: The control register (select 1) stores bit 6 = interrupt enable, bits 5:4 = receive level and bits 3:2 = transmit level. It reads back the same way, with all other bits 0.
- R4: A direction whose level is 0 never sets the change flag.
- R5: Level 1 reports a change only when the old state or the new state is bus-off (3).
- R6: Level 2 reports a change when the old state or the new state is error passive or bus-off (2 or more).
- R7: Level 3 reports every change of state.
- R8: The change flag is set in the clock after a reported change and stays set until software writes 1 to status bit 6. Writing 0 there leaves the flag unchanged. A reported change in the same clock as a clear write leaves the flag set.
- R9: Writes to the state bits of the status register have no effect on either state.
- R10: The interrupt output equals the change flag ANDed with the interrupt enable.
- R11: While `init_mode` is high, both states read 0 and the flag is not set. After `init_mode` falls, the move from OK to the counter-derived state is reported like any other change.
- R12: After reset, both registers read 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Controller initialisation mode; holds the states at OK |
| rx_err_cnt | input | CNT_W (9) | Receive error counter |
| tx_err_cnt | input | CNT_W (9) | Transmit error counter |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Status-change interrupt |

## Verification
The assertions assume the following about the inputs:

- Both counters are stable, known values at every clock edge.
- `reg_sel` is 0 or 1 whenever `reg_wr` is high.
- `init_mode` may change at any clock.

The stimulus drives every input on the falling edge, one field at a time. It holds the counters steady during register writes, so a clear write meets a state change only in the one scenario built to test that collision. The counter values are chosen on both sides of each threshold. This makes every state move the bench expects a deliberate one.

// File: rtl/can_esc_pkg.sv
package can_esc_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } err_state_e;

  localparam int FLAG_BIT = 6;
  localparam int RX_LSB   = 4;
  localparam int TX_LSB   = 2;

  localparam logic SEL_STATUS  = 1'b0;
  localparam logic SEL_CONTROL = 1'b1;

  // Map an error counter to its confinement state (R1)
  function automatic err_state_e classify_count(input logic [31:0] cnt,
                                                input logic [31:0] warn_at,
                                                input logic [31:0] passive_at,
                                                input logic [31:0] busoff_at);
    if (cnt >= busoff_at)       return ST_BUSOFF;
    else if (cnt >= passive_at) return ST_PASSIVE;
    else if (cnt >= warn_at)    return ST_WARN;
    else                        return ST_OK;
  endfunction

  // Decide whether a state move is reported under a given level (R4..R7)
  function automatic logic report_change(input logic [1:0] lvl,
                                         input err_state_e prev,
                                         input err_state_e nxt);
    logic moved;
    moved = (prev != nxt);
    case (lvl)
      2'd1:    return moved && (prev == ST_BUSOFF || nxt == ST_BUSOFF);
      2'd2:    return moved && (prev >= ST_PASSIVE || nxt >= ST_PASSIVE);
      2'd3:    return moved;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/can_esc_dir_track.sv
module can_esc_dir_track
  import can_esc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_AT    = 96,
  parameter int PASSIVE_AT = 128,
  parameter int BUSOFF_AT  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       level,
  output err_state_e       state,
  output logic             change_evt
);

  err_state_e nxt_state;

  always_comb begin
    if (init_mode)
      nxt_state = ST_OK;
    else
      nxt_state = classify_count(32'(cnt), 32'(WARN_AT), 32'(PASSIVE_AT), 32'(BUSOFF_AT));
    change_evt = !init_mode && report_change(level, state, nxt_state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OK;
    else        state <= nxt_state;
  end

endmodule

// File: rtl/can_esc_regs.sv
module can_esc_regs
  import can_esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  err_state_e rx_state,
  input  err_state_e tx_state,
  input  logic       rx_evt,
  input  logic       tx_evt,
  output logic [7:0] reg_rdata,
  output logic       chg_flag,
  output logic       chg_ie,
  output logic [1:0] rx_lvl,
  output logic [1:0] tx_lvl
);

  logic clr_hit;
  logic ctl_wr;
  logic set_evt;

  assign clr_hit = reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[FLAG_BIT];
  assign ctl_wr  = reg_wr && (reg_sel == SEL_CONTROL);
  assign set_evt = rx_evt || tx_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_flag <= 1'b0;
      chg_ie   <= 1'b0;
      rx_lvl   <= 2'd0;
      tx_lvl   <= 2'd0;
    end else begin
      if (set_evt)      chg_flag <= 1'b1;
      else if (clr_hit) chg_flag <= 1'b0;
      if (ctl_wr) begin
        chg_ie <= reg_wdata[FLAG_BIT];
        rx_lvl <= reg_wdata[RX_LSB +: 2];
        tx_lvl <= reg_wdata[TX_LSB +: 2];
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_sel == SEL_STATUS) begin
      reg_rdata[FLAG_BIT]     = chg_flag;
      reg_rdata[RX_LSB +: 2]  = rx_state;
      reg_rdata[TX_LSB +: 2]  = tx_state;
    end else begin
      reg_rdata[FLAG_BIT]     = chg_ie;
      reg_rdata[RX_LSB +: 2]  = rx_lvl;
      reg_rdata[TX_LSB +: 2]  = tx_lvl;
    end
  end

endmodule

// File: rtl/can_err_state_irq.sv
module can_err_state_irq
  import can_esc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_AT    = 96,
  parameter int PASSIVE_AT = 128,
  parameter int BUSOFF_AT  = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_mode,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);

  localparam int NUM_DIR = 2;

  err_state_e rx_state, tx_state;
  logic       rx_evt, tx_evt;
  logic       chg_flag, chg_ie;
  logic [1:0] rx_lvl, tx_lvl;

  logic [CNT_W-1:0] dir_cnt [NUM_DIR];
  logic [1:0]       dir_lvl [NUM_DIR];
  err_state_e       dir_st  [NUM_DIR];
  logic             dir_evt [NUM_DIR];

  assign dir_cnt[0] = rx_err_cnt;
  assign dir_cnt[1] = tx_err_cnt;
  assign dir_lvl[0] = rx_lvl;
  assign dir_lvl[1] = tx_lvl;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    can_esc_dir_track #(
      .CNT_W(CNT_W), .WARN_AT(WARN_AT), .PASSIVE_AT(PASSIVE_AT), .BUSOFF_AT(BUSOFF_AT)
    ) u_track (
      .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
      .cnt(dir_cnt[d]), .level(dir_lvl[d]),
      .state(dir_st[d]), .change_evt(dir_evt[d])
    );
  end

  assign rx_state = dir_st[0];
  assign tx_state = dir_st[1];
  assign rx_evt   = dir_evt[0];
  assign tx_evt   = dir_evt[1];

  can_esc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rx_state(rx_state), .tx_state(tx_state),
    .rx_evt(rx_evt), .tx_evt(tx_evt),
    .reg_rdata(reg_rdata),
    .chg_flag(chg_flag), .chg_ie(chg_ie),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl)
  );

  assign irq = chg_flag && chg_ie;

endmodule

// File: rtl/can_err_state_irq_chk.sv
module can_err_state_irq_chk
  import can_esc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int WARN_AT    = 96,
  parameter int PASSIVE_AT = 128,
  parameter int BUSOFF_AT  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_mode,
  input logic [CNT_W-1:0] rx_err_cnt,
  input logic             reg_wr,
  input logic             reg_sel,
  input logic [7:0]       reg_wdata,
  input logic             irq,
  input err_state_e       rx_state,
  input err_state_e       tx_state,
  input logic             rx_evt,
  input logic             tx_evt,
  input logic             chg_flag,
  input logic             chg_ie,
  input logic [1:0]       rx_lvl
);

  logic clr_wr;
  assign clr_wr = reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[FLAG_BIT];

  assert_rx_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> rx_state == classify_count(32'($past(rx_err_cnt)), 32'(WARN_AT),
                                              32'(PASSIVE_AT), 32'(BUSOFF_AT)));

  assert_level0_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl == 2'd0) |-> !rx_evt);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> $past(rx_evt || tx_evt));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !rx_evt && !tx_evt) |=> !chg_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !clr_wr) |=> chg_flag);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_ie |-> !irq);

  assert_init_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> (rx_state == ST_OK && tx_state == ST_OK));

  assert_init_no_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode && !chg_flag) |=> !chg_flag);

endmodule

bind can_err_state_irq can_err_state_irq_chk #(
  .CNT_W(CNT_W), .WARN_AT(WARN_AT), .PASSIVE_AT(PASSIVE_AT), .BUSOFF_AT(BUSOFF_AT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .rx_err_cnt(rx_err_cnt),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .irq(irq),
  .rx_state(rx_state), .tx_state(tx_state), .rx_evt(rx_evt), .tx_evt(tx_evt),
  .chg_flag(chg_flag), .chg_ie(chg_ie), .rx_lvl(rx_lvl)
);

// File: tb/can_err_state_irq_tb.sv
module can_err_state_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init_mode = 1'b0;
  logic [CW-1:0] rx_err_cnt = '0;
  logic [CW-1:0] tx_err_cnt = '0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  int m_rx = 0, m_tx = 0, m_rxl = 0, m_txl = 0;
  bit m_flag = 0, m_ie = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_state_irq u_dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int exp_state(input int c);
    if (c < 96)  return 0;
    if (c < 128) return 1;
    if (c < 256) return 2;
    return 3;
  endfunction

  function automatic bit exp_report(input int lvl, input int a, input int b);
    if (a == b) return 0;
    if (lvl == 3) return 1;
    if (lvl == 2) return (a > 1) || (b > 1);
    if (lvl == 1) return (a == 3) || (b == 3);
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int status_byte();
    return (int'(m_flag) << 6) | (m_rx << 4) | (m_tx << 2);
  endfunction

  task automatic read_reg(input logic sel, output int val);
    reg_sel = sel;
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic write_reg(input logic sel, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = 8'(data);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; reg_sel = 1'b0;
    if (sel == 1'b0) begin
      if (data[6]) m_flag = 0;
    end else begin
      m_ie = data[6]; m_rxl = (data >> 4) & 3; m_txl = (data >> 2) & 3;
    end
  endtask

  // present counters, advance one clock, compare status against the model
  task automatic apply(input int rxc, input int txc, input string req);
    int nrx, ntx, v;
    @(negedge clk);
    rx_err_cnt = CW'(rxc); tx_err_cnt = CW'(txc);
    nrx = init_mode ? 0 : exp_state(rxc);
    ntx = init_mode ? 0 : exp_state(txc);
    if (!init_mode && (exp_report(m_rxl, m_rx, nrx) || exp_report(m_txl, m_tx, ntx)))
      m_flag = 1;
    m_rx = nrx; m_tx = ntx;
    @(negedge clk); #1;
    read_reg(1'b0, v);
    check(req, v, status_byte());
  endtask

  task automatic t_reset();
    int v;
    read_reg(1'b0, v); check("R12 status after reset", v, 0);
    read_reg(1'b1, v); check("R12 control after reset", v, 0);
    check("R12 irq after reset", int'(irq), 0);
  endtask

  task automatic t_control_rw();
    int v;
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, v); check("R3 control readback of all-ones", v, 8'h7C);
    write_reg(1'b1, 8'h00);
    read_reg(1'b1, v); check("R3 control readback zero", v, 0);
  endtask

  task automatic t_thresholds();
    write_reg(1'b1, 8'h3C);  // level 3 both, ie off
    apply(95, 0, "R1 rx 95 stays OK");
    apply(96, 0, "R1 rx 96 warning");
    apply(127, 95, "R1 rx 127 warning");
    apply(128, 96, "R1 rx 128 passive, tx 96 warning");
    apply(255, 128, "R1 rx 255 passive, tx 128 passive");
    apply(256, 255, "R1 R2 rx 256 bus-off");
    apply(256, 256, "R1 R7 tx 256 bus-off");
    check("R10 irq low with enable off", int'(irq), 0);
    write_reg(1'b0, 8'h40);
    apply(0, 0, "R7 return to OK reported");
    write_reg(1'b0, 8'h40);
    apply(0, 0, "R8 cleared flag stays clear");
  endtask

  task automatic t_level1();
    write_reg(1'b1, 8'h44);  // ie on, rx level 0, tx level 1
    apply(0, 100, "R5 warning not reported");
    apply(0, 130, "R5 passive not reported");
    check("R10 irq low without flag", int'(irq), 0);
    apply(0, 300, "R5 bus-off entry reported");
    check("R10 irq high with flag and enable", int'(irq), 1);
    write_reg(1'b0, 8'h00);
    apply(0, 300, "R8 write 0 keeps flag");
    write_reg(1'b0, 8'h40);
    check("R10 irq low after clear", int'(irq), 0);
    apply(0, 0, "R5 bus-off exit reported");
    write_reg(1'b0, 8'h40);
  endtask

  task automatic t_level2();
    write_reg(1'b1, 8'h20);  // rx level 2, tx level 0
    apply(100, 0, "R6 OK to warning not reported");
    apply(128, 0, "R6 entry to passive reported");
    write_reg(1'b0, 8'h40);
    apply(100, 100, "R6 exit from passive reported, R4 tx silent");
    write_reg(1'b0, 8'h40);
    apply(0, 300, "R4 level 0 tx bus-off silent, R6 rx warn to OK silent");
  endtask

  task automatic t_readonly();
    int v;
    write_reg(1'b0, 8'h3C);
    read_reg(1'b0, v); check("R9 state bits unaffected by write", v, status_byte());
  endtask

  task automatic t_set_wins();
    int v;
    write_reg(1'b1, 8'h3C);
    @(negedge clk);
    rx_err_cnt = CW'(200);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h40;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    m_rx = 2; m_flag = 1;
    #1; read_reg(1'b0, v); check("R8 set wins over clear", v, status_byte());
    write_reg(1'b0, 8'h40);
  endtask

  task automatic t_init();
    int v;
    @(negedge clk); init_mode = 1'b1;
    m_rx = 0; m_tx = 0;
    apply(300, 300, "R11 init holds states OK, no flag");
    apply(100, 200, "R11 init ignores counters");
    @(negedge clk); init_mode = 1'b0;
    m_rx = 1; m_tx = 2; m_flag = 1;
    @(negedge clk); #1;
    read_reg(1'b0, v); check("R11 exit from init reported", v, status_byte());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control_rw();
    t_thresholds();
    t_level1();
    t_level2();
    t_readonly();
    t_set_wins();
    t_init();
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule